// File: doc/BRIEF.md
# Four-Digit Seven-Segment Scan Multiplexer

This block drives a four-digit common-cathode seven-segment display from one shared segment bus. A divider on the system clock generates its own scan timebase, so no separate scan clock is needed. Each digit slot lasts one scan period, and only one digit strobe is high at a time. The digits are visited from the least significant to the most significant position and the sequence then repeats.

Two four-digit BCD words enter the block. One is the live value of a counter and the other is a held (latched) copy of it. A select input picks which word is shown. Each BCD nibble is decoded to segment levels in which a lit segment is a high level. Codes above nine show nothing. At the start of every digit slot there is a short dark interval with all strobes and segments off, which keeps the previous digit's pattern from smearing onto the next position.

Top module: `mux7_scanner`

## Requirements
- R1: While reset is high, and for the first BLANK_CYC cycles after it is released, every strobe and every segment is low. The scan starts at digit 0.
- R2: At most one digit strobe is high in any cycle.
- R3: Each digit slot lasts exactly CLK_HZ/SCAN_HZ clock cycles. Strobe bit i (digit i, where bit 0 is the least significant nibble) is followed by bit i+1, and bit 3 is followed by bit 0.
- R4: During the first BLANK_CYC cycles of every digit slot, all strobes and all segments are low.
- R5: With `show_live` high, the lit digit i shows nibble i (bits 4i+3..4i) of `live_val`. With it low, the lit digit shows nibble i of `held_val`. The choice follows `show_live` in the same cycle.
- R6: Segments are active high, with `seg[0]`=a through `seg[6]`=g. Digits 0..9 map to the hex codes 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F.
- R7: A nibble of 10 to 15 on the lit digit drives all seven segments low.
- R8: Changing `live_val`, `held_val` or `show_live` never alters the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the source of the scan timebase |
| rst | input | 1 | Asynchronous active-high reset |
| live_val | input | 4*NDIG | Live BCD value, digit 0 in the low nibble |
| held_val | input | 4*NDIG | Held BCD value, digit 0 in the low nibble |
| show_live | input | 1 | 1 shows live_val, 0 shows held_val |
| strobe | output | NDIG | One-hot digit enables, active high |
| seg | output | 7 | Segments a..g on bits 0..6, active high |

## Verification
The bench uses a small divider of eight cycles per slot with two dark cycles. It sweeps sixteen rotating nibble patterns, so that every position sees all sixteen codes. The held word always differs from the live word, which lets a swapped source or a mis-sliced nibble show up as a wrong segment pattern instead of hiding behind equal data. Each pattern runs under both select levels. Inputs change in the middle of slots and the strobe timing is compared against a cycle count kept by the bench, which separates timebase faults from data-path faults.

// File: rtl/mux7_pkg.sv
package mux7_pkg;
   typedef logic [3:0] bcd_t;
   typedef logic [6:0] seg_t;
   localparam seg_t SEG_DARK = 7'h00;
endpackage

// File: rtl/mux7_timer.sv
module mux7_timer #(
   parameter int DIV       = 8,
   parameter int NDIG      = 4,
   parameter int BLANK_CYC = 2
) (
   input  logic                    clk,
   input  logic                    rst,
   output logic [$clog2(NDIG)-1:0] idx,
   output logic                    dark
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam int IW = $clog2(NDIG);
   localparam logic [CW-1:0] LAST_CNT = CW'(DIV - 1);
   localparam logic [IW-1:0] LAST_IDX = IW'(NDIG - 1);
   localparam logic [CW-1:0] DARK_END = CW'(BLANK_CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cnt <= '0;
         idx <= '0;
      end else if (cnt == LAST_CNT) begin
         cnt <= '0;
         idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign dark = (cnt < DARK_END);
endmodule

// File: rtl/mux7_pick.sv
module mux7_pick
   import mux7_pkg::*;
#(
   parameter int NDIG = 4
) (
   input  logic [4*NDIG-1:0]       live_val,
   input  logic [4*NDIG-1:0]       held_val,
   input  logic                    show_live,
   input  logic [$clog2(NDIG)-1:0] idx,
   output bcd_t                    digit
);
   bcd_t live_d [NDIG];
   bcd_t held_d [NDIG];

   for (genvar i = 0; i < NDIG; i++) begin : g_slice
      assign live_d[i] = live_val[4*i +: 4];
      assign held_d[i] = held_val[4*i +: 4];
   end

   assign digit = show_live ? live_d[idx] : held_d[idx];
endmodule

// File: rtl/mux7_decode.sv
module mux7_decode
   import mux7_pkg::*;
(
   input  bcd_t code,
   output seg_t pattern
);
   always_comb begin
      case (code)
         4'd0:    pattern = 7'h3F;
         4'd1:    pattern = 7'h06;
         4'd2:    pattern = 7'h5B;
         4'd3:    pattern = 7'h4F;
         4'd4:    pattern = 7'h66;
         4'd5:    pattern = 7'h6D;
         4'd6:    pattern = 7'h7D;
         4'd7:    pattern = 7'h07;
         4'd8:    pattern = 7'h7F;
         4'd9:    pattern = 7'h6F;
         default: pattern = SEG_DARK;
      endcase
   end
endmodule

// File: rtl/mux7_scanner.sv
module mux7_scanner
   import mux7_pkg::*;
#(
   parameter int CLK_HZ    = 50_000_000,
   parameter int SCAN_HZ   = 1000,
   parameter int NDIG      = 4,
   parameter int BLANK_CYC = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [4*NDIG-1:0] live_val,
   input  logic [4*NDIG-1:0] held_val,
   input  logic              show_live,
   output logic [NDIG-1:0]   strobe,
   output logic [6:0]        seg
);
   localparam int DIV = CLK_HZ / SCAN_HZ;
   localparam int IW  = $clog2(NDIG);

   if (NDIG < 2) begin : g_bad_ndig
      $error("mux7_scanner: NDIG must be at least 2");
   end
   if (DIV < 2) begin : g_bad_div
      $error("mux7_scanner: CLK_HZ/SCAN_HZ must be at least 2");
   end
   if (BLANK_CYC < 1 || BLANK_CYC >= DIV) begin : g_bad_blank
      $error("mux7_scanner: BLANK_CYC must lie in 1..DIV-1");
   end

   logic [IW-1:0] idx;
   logic          dark;
   bcd_t          cur_bcd;
   seg_t          cur_seg;

   mux7_timer #(.DIV(DIV), .NDIG(NDIG), .BLANK_CYC(BLANK_CYC)) u_timer (
      .clk  (clk),
      .rst  (rst),
      .idx  (idx),
      .dark (dark)
   );

   mux7_pick #(.NDIG(NDIG)) u_pick (
      .live_val  (live_val),
      .held_val  (held_val),
      .show_live (show_live),
      .idx       (idx),
      .digit     (cur_bcd)
   );

   mux7_decode u_dec (
      .code    (cur_bcd),
      .pattern (cur_seg)
   );

   for (genvar i = 0; i < NDIG; i++) begin : g_strobe
      assign strobe[i] = !dark && (idx == IW'(i));
   end

   assign seg = dark ? SEG_DARK : cur_seg;
endmodule

// File: rtl/mux7_scanner_chk.sv
module mux7_scanner_chk #(
   parameter int DIV  = 8,
   parameter int NDIG = 4
) (
   input logic            clk,
   input logic            rst,
   input logic [NDIG-1:0] strobe,
   input logic [6:0]      seg,
   input logic [3:0]      digit
);
   localparam int GW = $clog2(DIV + 1) + 1;

   logic            lit, lit_d, seen;
   logic [NDIG-1:0] last_lit;
   logic [GW-1:0]   gap;

   assign lit = |strobe;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         lit_d    <= 1'b0;
         seen     <= 1'b0;
         last_lit <= '0;
         gap      <= '0;
      end else begin
         lit_d <= lit;
         if (lit) last_lit <= strobe;
         if (lit && !lit_d) begin
            seen <= 1'b1;
            gap  <= GW'(1);
         end else if (gap != '1) begin
            gap <= gap + 1'b1;
         end
      end
   end

   // R2
   p_onehot_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(strobe));

   // R4
   p_dark_segs_r4: assert property (@(posedge clk) disable iff (rst)
      (strobe == '0) |-> (seg == 7'h00));

   // R3: next lit position is the neighbour of the previous one
   p_advance_r3: assert property (@(posedge clk) disable iff (rst)
      (lit && !lit_d && seen) |->
      (strobe == {last_lit[NDIG-2:0], last_lit[NDIG-1]}));

   // R3: slot length
   p_period_r3: assert property (@(posedge clk) disable iff (rst)
      (lit && !lit_d && seen) |-> (gap == GW'(DIV)));

   // R7
   p_code_off_r7: assert property (@(posedge clk) disable iff (rst)
      (lit && digit > 4'd9) |-> (seg == 7'h00));
endmodule

bind mux7_scanner mux7_scanner_chk #(.DIV(CLK_HZ / SCAN_HZ), .NDIG(NDIG)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .strobe (strobe),
   .seg    (seg),
   .digit  (cur_bcd)
);

// File: tb/mux7_scanner_test.sv
module mux7_scanner_test;
   localparam int CLK_HZ  = 8000;
   localparam int SCAN_HZ = 1000;
   localparam int DIV     = CLK_HZ / SCAN_HZ;
   localparam int BLANK   = 2;
   localparam int NDIG    = 4;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] live_val = '0;
   logic [15:0] held_val = '0;
   logic        show_live = 1'b0;
   logic [3:0]  strobe;
   logic [6:0]  seg;

   int checks = 0;
   int fails  = 0;
   int m      = 0;

   always #10 clk = ~clk;

   mux7_scanner #(.CLK_HZ(CLK_HZ), .SCAN_HZ(SCAN_HZ), .NDIG(NDIG), .BLANK_CYC(BLANK)) uut (
      .clk       (clk),
      .rst       (rst),
      .live_val  (live_val),
      .held_val  (held_val),
      .show_live (show_live),
      .strobe    (strobe),
      .seg       (seg)
   );

   always_ff @(posedge clk) begin
      if (rst) m <= 0;
      else     m <= m + 1;
   end

   function automatic logic [6:0] ref_seg(input logic [3:0] v);
      case (v)
         4'd0: return 7'h3F;
         4'd1: return 7'h06;
         4'd2: return 7'h5B;
         4'd3: return 7'h4F;
         4'd4: return 7'h66;
         4'd5: return 7'h6D;
         4'd6: return 7'h7D;
         4'd7: return 7'h07;
         4'd8: return 7'h7F;
         4'd9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   task automatic check_now();
      int ph  = m % DIV;
      int pos = (m / DIV) % NDIG;
      logic [3:0] exp_str;
      logic [3:0] nib;
      logic [6:0] exp_seg;
      nib     = show_live ? live_val[4*pos +: 4] : held_val[4*pos +: 4];
      exp_str = (ph < BLANK) ? 4'b0 : 4'(1 << pos);
      exp_seg = (ph < BLANK) ? 7'h00 : ref_seg(nib);
      checks++;
      if ($countones(strobe) > 1) begin
         fails++;
         $display("FAIL R2 strobe=%b expected at most one high", strobe);
      end
      checks++;
      if (strobe !== exp_str) begin
         fails++;
         $display("FAIL %s/R8 strobe=%b expected=%b (m=%0d)",
                  (ph < BLANK) ? "R4" : "R3", strobe, exp_str, m);
      end
      checks++;
      if (seg !== exp_seg) begin
         fails++;
         if (ph < BLANK)
            $display("FAIL R4 seg=%h expected=%h", seg, exp_seg);
         else if (nib > 4'd9)
            $display("FAIL R7 seg=%h expected=%h code=%0d", seg, exp_seg, nib);
         else
            $display("FAIL R5/R6 seg=%h expected=%h code=%0d live=%b", seg, exp_seg, nib, show_live);
      end
   endtask

   initial begin
      live_val = 16'h4321;
      held_val = 16'h8765;
      repeat (3) @(negedge clk);
      // R1: outputs dark while in reset
      checks++;
      if (strobe !== 4'b0 || seg !== 7'h00) begin
         fails++;
         $display("FAIL R1 strobe=%b seg=%h expected=0000 00", strobe, seg);
      end
      rst = 1'b0;
      // R1: dark right after release, then digit 0
      for (int k = 0; k < DIV; k++) begin
         check_now();
         @(negedge clk);
      end
      for (int s = 0; s < 2; s++) begin
         for (int v = 0; v < 16; v++) begin
            for (int c = 0; c < NDIG * DIV; c++) begin
               check_now();
               if (c == 5) begin
                  // R8: new data and select mid-slot
                  show_live = (s == 1);
                  for (int p = 0; p < NDIG; p++) begin
                     live_val[4*p +: 4] = 4'(v + p);
                     held_val[4*p +: 4] = 4'(15 - v + 3 * p);
                  end
               end
               if (c == 13) show_live = ~show_live;
               if (c == 21) show_live = (s == 1);
               @(negedge clk);
            end
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule